// File: doc/BRIEF.md
# Burst Column Address Generator

This block keeps the burst settings of a synchronous DRAM and, for every read or write burst, produces the column addresses of that burst, one per clock. A mode write loads a 12-bit operation code. The code gives the burst length, the ordering (linear or XOR-interleaved), the CAS latency and a write-single option. A burst start supplies the first column and a read/write flag. From the next cycle the block presents one column per enabled clock, together with a valid flag and a flag that marks the final beat.

A clock-enable input suspends the block. While it is low every register holds its value, and all requests are ignored. A stop request ends a running burst. A new start at any time, including during a burst, abandons the running burst and begins the new one. An illegal operation code is rejected and reported for one cycle, and the stored settings are left unchanged.

Top module: `burst_colgen`

## Requirements
- R1: After reset, col_valid, col_last and mode_err are 0, cas_lat is 2, and the settings are burst length 1, sequential ordering and writes using the programmed length.
- R2: Operation code bits [2:0] set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. col_last is 1 exactly on the final beat, and col_valid falls in the next enabled cycle unless a new start arrives.
- R3: With bit [3] = 0 (sequential), beat n presents the low burst-window bits of (start + n), wrapping inside the aligned window. For example, start 5 at length 8 gives 5,6,7,0,1,2,3,4.
- R4: With bit [3] = 1 (interleaved), beat n presents the start XOR n within the window. For example, start 5 at length 8 gives 5,4,7,6,1,0,3,2.
- R5: A full-page burst counts through all 2^COL_W columns sequentially, wrapping from the top column to column 0. Full page combined with interleaved ordering is illegal.
- R6: Bits [6:4] set the CAS latency presented on cas_lat: 001 gives 1, 010 gives 2 and 011 gives 3. Every other value is illegal. Bits [8:7] and [11:10] must be 0.
- R7: When bit [9] = 1, a write burst (start_is_wr = 1) is a single beat. Read bursts keep the programmed length. When bit [9] = 0, writes use the programmed length.
- R8: While cke is 0, col_addr, col_valid, col_last, cas_lat and mode_err hold. burst_start, burst_stop and mode_wr are ignored, and the burst resumes from the same beat when cke returns to 1.
- R9: A mode write with an illegal code leaves the settings unchanged and raises mode_err for exactly the next enabled cycle. A legal mode write clears it.
- R10: Column bits above the burst window equal those of the start column for the whole burst.
- R11: burst_stop ends a running burst, so col_valid is 0 in the next cycle. burst_start takes priority over burst_stop, and a start during a burst restarts the burst at beat 0 with the new column.
- R12: Length, ordering and write-single are captured at burst start. A mode write during a burst changes only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the block |
| mode_wr | input | 1 | Load the settings from mode_op |
| mode_op | input | 12 | Operation code |
| burst_start | input | 1 | Begin a burst at start_col |
| start_col | input | COL_W | First column of the burst |
| start_is_wr | input | 1 | Burst is a write |
| burst_stop | input | 1 | End the running burst |
| col_addr | output | COL_W | Column of the current beat |
| col_valid | output | 1 | col_addr carries a beat |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Programmed CAS latency (1 to 3) |
| mode_err | output | 1 | Previous enabled cycle rejected a mode write |

## Verification
The assertions assume that the inputs are 0 or 1 (never X) at each rising edge after reset. They also assume that start_col is meaningful only together with burst_start. No input timing beyond that is assumed, so stop, start and mode writes may coincide in any combination and at any point of a burst. The random stimulus draws every input independently at each clock. It mixes legal codes with raw 12-bit codes and drops cke in about one cycle in ten, so it stays within these assumptions while still reaching restarts, coincident stop and start, and suspension in the middle of a burst.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

    localparam int OP_W = 12;

    typedef struct packed {
        logic [2:0] len_code;
        logic       ileave;
        logic [1:0] cas_lat;
        logic       wr_single;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{
        len_code:  3'b000,
        ileave:    1'b0,
        cas_lat:   2'd2,
        wr_single: 1'b0
    };

    // Legal operation codes: length 1/2/4/8 any order, full page sequential only,
    // latency 1..3, test and spare fields zero.
    function automatic logic op_legal(input logic [OP_W-1:0] op);
        logic len_ok;
        logic lat_ok;
        len_ok = (op[2] == 1'b0) || (op[2:0] == 3'b111 && op[3] == 1'b0);
        lat_ok = (op[6] == 1'b0) && (op[5:4] != 2'b00);
        return len_ok && lat_ok && (op[8:7] == 2'b00) && (op[11:10] == 2'b00);
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_colgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke,
    input  logic            mode_wr,
    input  logic [OP_W-1:0] mode_op,
    output burst_cfg_t      cfg_o,
    output logic            mode_err
);

    typedef struct packed {
        burst_cfg_t cfg;
        logic       err;
    } mreg_t;

    mreg_t mreg_d, mreg_q;

    always_comb begin
        mreg_d = mreg_q;
        if (cke) begin
            mreg_d.err = 1'b0;
            if (mode_wr) begin
                if (op_legal(mode_op)) begin
                    mreg_d.cfg.len_code  = mode_op[2:0];
                    mreg_d.cfg.ileave    = mode_op[3];
                    mreg_d.cfg.cas_lat   = mode_op[5:4];
                    mreg_d.cfg.wr_single = mode_op[9];
                end else begin
                    mreg_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mreg_q <= '{cfg: CFG_RESET, err: 1'b0};
        end else begin
            mreg_q <= mreg_d;
        end
    end

    assign cfg_o    = mreg_q.cfg;
    assign mode_err = mreg_q.err;

    assert_reject_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && mode_wr && !op_legal(mode_op)) |=> (mode_err && $stable(cfg_o)));

    assert_cas_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o.cas_lat != 2'd0);

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(cfg_o) && $stable(mode_err)));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  burst_cfg_t       cfg_i,
    input  logic             burst_start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_is_wr,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last
);

    localparam logic [COL_W-1:0] PAGE_MASK = '1;

    typedef struct packed {
        logic             act;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic             ileave;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [COL_W-1:0] len_mask;
    logic [COL_W-1:0] window;

    // Window mask is burst length minus one; it also marks the final beat.
    always_comb begin
        case (cfg_i.len_code)
            3'b000:  len_mask = '0;
            3'b001:  len_mask = COL_W'(1);
            3'b010:  len_mask = COL_W'(3);
            3'b011:  len_mask = COL_W'(7);
            default: len_mask = PAGE_MASK;
        endcase
    end

    always_comb begin
        seq_d = seq_q;
        if (cke) begin
            if (burst_start) begin
                seq_d.act    = 1'b1;
                seq_d.beat   = '0;
                seq_d.base   = start_col;
                seq_d.mask   = (start_is_wr && cfg_i.wr_single) ? '0 : len_mask;
                seq_d.ileave = cfg_i.ileave;
            end else if (burst_stop) begin
                seq_d.act = 1'b0;
            end else if (seq_q.act) begin
                if (seq_q.beat == seq_q.mask) begin
                    seq_d.act = 1'b0;
                end else begin
                    seq_d.beat = seq_q.beat + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign window    = seq_q.ileave ? (seq_q.base ^ seq_q.beat) : (seq_q.base + seq_q.beat);
    assign col_addr  = (seq_q.base & ~seq_q.mask) | (window & seq_q.mask);
    assign col_valid = seq_q.act;
    assign col_last  = seq_q.act && (seq_q.beat == seq_q.mask);

    assert_start_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && burst_start) |=> (col_valid && col_addr == $past(start_col)));

    assert_stop_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && burst_stop && !burst_start) |=> !col_valid);

    assert_last_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && col_last && !burst_start) |=> !col_valid);

    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col_addr) && $stable(col_valid) && $stable(col_last)));

    assert_upper_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !burst_start) |=>
            (!col_valid || ((col_addr & ~seq_q.mask) == $past(col_addr & ~seq_q.mask))));

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             mode_wr,
    input  logic [11:0]      mode_op,
    input  logic             burst_start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_is_wr,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic [1:0]       cas_lat,
    output logic             mode_err
);

    burst_cfg_t cfg;

    burst_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .mode_wr  (mode_wr),
        .mode_op  (mode_op),
        .cfg_o    (cfg),
        .mode_err (mode_err)
    );

    burst_seq #(.COL_W(COL_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .cfg_i       (cfg),
        .burst_start (burst_start),
        .start_col   (start_col),
        .start_is_wr (start_is_wr),
        .burst_stop  (burst_stop),
        .col_addr    (col_addr),
        .col_valid   (col_valid),
        .col_last    (col_last)
    );

    assign cas_lat = cfg.cas_lat;

    assert_cas_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cas_lat == 2'd2));

endmodule

// File: tb/burst_colgen_bench.sv
`timescale 1ns/1ps
module burst_colgen_bench;

    localparam int COL_W = 9;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cke = 1'b1;
    logic             mode_wr = 1'b0;
    logic [11:0]      mode_op = '0;
    logic             burst_start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             start_is_wr = 1'b0;
    logic             burst_stop = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;
    logic [1:0]       cas_lat;
    logic             mode_err;

    always #5 clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) u_burst_colgen (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    int m_act = 0, m_beat = 0, m_base = 0, m_mask = 0, m_il = 0;
    int c_len = 0, c_il = 0, c_cl = 2, c_ws = 0, m_err = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit legal(input logic [11:0] op);
        bit ok = 1;
        if (!(op[2:0] inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7})) ok = 0;
        if (op[2:0] == 3'd7 && op[3]) ok = 0;
        if (!(op[6:4] inside {3'd1, 3'd2, 3'd3})) ok = 0;
        if (op[8:7] != 0 || op[11:10] != 0) ok = 0;
        return ok;
    endfunction

    function automatic int len_mask(input int code);
        case (code)
            0: return 0;
            1: return 1;
            2: return 3;
            3: return 7;
            default: return PAGE - 1;
        endcase
    endfunction

    function automatic int exp_addr();
        int w = m_il ? (m_base ^ m_beat) : (m_base + m_beat);
        return ((m_base & ~m_mask) | (w & m_mask)) & (PAGE - 1);
    endfunction

    task automatic step(input bit mw, input logic [11:0] op, input bit st, input int sc,
                        input bit wr, input bit sp, input bit ce, input string tag);
        mode_wr = mw; mode_op = op; burst_start = st; start_col = sc[COL_W-1:0];
        start_is_wr = wr; burst_stop = sp; cke = ce;
        @(posedge clk);
        if (ce) begin
            if (st) begin
                m_act = 1; m_beat = 0; m_base = sc & (PAGE - 1);
                m_mask = (wr && c_ws != 0) ? 0 : len_mask(c_len); m_il = c_il;
            end else if (sp) begin
                m_act = 0;
            end else if (m_act != 0) begin
                if (m_beat == m_mask) m_act = 0; else m_beat++;
            end
            if (mw) begin
                if (legal(op)) begin
                    c_len = op[2:0]; c_il = op[3]; c_cl = op[6:4]; c_ws = op[9]; m_err = 0;
                end else m_err = 1;
            end else m_err = 0;
        end
        #2;
        check(tag, "col_valid", col_valid, m_act);
        check(tag, "col_last", col_last, (m_act != 0 && m_beat == m_mask) ? 1 : 0);
        if (m_act != 0) check(tag, "col_addr", col_addr, exp_addr());
        check(tag, "mode_err", mode_err, m_err);
        check(tag, "cas_lat", cas_lat, c_cl);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 1, tag);
    endtask

    task automatic mode(input logic [11:0] op, input string tag);
        step(1, op, 0, 0, 0, 0, 1, tag);
    endtask

    task automatic burst_list(input int sc, input int exp[8], input string tag);
        step(0, '0, 1, sc, 0, 0, 1, tag);
        check(tag, "literal beat 0", col_addr, exp[0]);
        for (int i = 1; i < 8; i++) begin
            step(0, '0, 0, 0, 0, 0, 1, tag);
            check(tag, "literal beat", col_addr, exp[i]);
        end
        check(tag, "last on beat 7", col_last, 1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        string tg;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        #1;
        check("R1", "col_valid in reset", col_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "col_valid", col_valid, 0);
        check("R1", "col_last", col_last, 0);
        check("R1", "mode_err", mode_err, 0);
        check("R1", "cas_lat", cas_lat, 2);
        step(0, '0, 1, 9'h0A3, 1, 0, 1, "R1");          // reset length 1
        check("R1", "single beat after reset", col_last, 1);
        idle(2, "R1");

        // R2: each finite length
        mode(12'h010, "R2"); step(0, '0, 1, 6, 0, 0, 1, "R2"); idle(2, "R2");
        mode(12'h011, "R2"); step(0, '0, 1, 6, 0, 0, 1, "R2"); idle(3, "R2");
        mode(12'h012, "R2"); step(0, '0, 1, 6, 0, 0, 1, "R2"); idle(5, "R2");

        // R6: latency codes
        mode(12'h033, "R6");
        check("R6", "cas_lat 3", cas_lat, 3);
        mode(12'h013, "R6");
        mode(12'h023, "R6");
        mode(12'h033, "R6");

        // R3 / R4 literal orderings
        burst_list(5, '{5, 6, 7, 0, 1, 2, 3, 4}, "R3");
        idle(1, "R3");
        mode(12'h03B, "R4");
        burst_list(5, '{5, 4, 7, 6, 1, 0, 3, 2}, "R4");
        idle(1, "R4");

        // R10: upper bits kept
        mode(12'h033, "R10");
        burst_list(9'h1F5, '{9'h1F5, 9'h1F6, 9'h1F7, 9'h1F0, 9'h1F1, 9'h1F2, 9'h1F3, 9'h1F4}, "R10");
        idle(1, "R10");

        // R5: full page wraps
        mode(12'h037, "R5");
        step(0, '0, 1, 9'h1FE, 0, 0, 1, "R5");
        step(0, '0, 0, 0, 0, 0, 1, "R5");
        step(0, '0, 0, 0, 0, 0, 1, "R5");
        check("R5", "wrap to column 0", col_addr, 0);
        idle(PAGE - 3, "R5");
        check("R5", "last at beat page-1", col_last, 1);
        idle(1, "R5");
        check("R5", "done after page", col_valid, 0);

        // R9: illegal codes rejected
        mode(12'h03F, "R9");
        check("R9", "full page interleaved rejected", mode_err, 1);
        mode(12'h003, "R9");
        mode(12'h0B3, "R9");
        mode(12'h433, "R9");
        mode(12'h034, "R9");
        idle(1, "R9");
        check("R9", "error clears", mode_err, 0);
        step(0, '0, 1, 3, 0, 0, 1, "R9"); idle(2, "R9");  // still full page
        check("R9", "settings kept", col_valid, 1);
        step(0, '0, 0, 0, 0, 1, 1, "R9");

        // R7: write single
        mode(12'h233, "R7");
        step(0, '0, 1, 12, 1, 0, 1, "R7");
        check("R7", "write single last", col_last, 1);
        step(0, '0, 0, 0, 0, 0, 1, "R7");
        check("R7", "write single ends", col_valid, 0);
        step(0, '0, 1, 12, 0, 0, 1, "R7"); idle(8, "R7");
        mode(12'h033, "R7");
        step(0, '0, 1, 12, 1, 0, 1, "R7"); idle(8, "R7");

        // R8: suspension
        step(0, '0, 1, 2, 0, 0, 1, "R8");
        step(0, '0, 0, 0, 0, 0, 1, "R8");
        step(1, 12'h3FF, 1, 100, 0, 1, 0, "R8");
        step(0, '0, 1, 77, 0, 1, 0, "R8");
        check("R8", "frozen address", col_addr, 3);
        idle(7, "R8");

        // R11: stop and restart
        step(0, '0, 1, 40, 0, 0, 1, "R11");
        step(0, '0, 0, 0, 0, 1, 1, "R11");
        check("R11", "stop ends", col_valid, 0);
        step(0, '0, 1, 40, 0, 0, 1, "R11");
        step(0, '0, 1, 50, 0, 0, 1, "R11");
        check("R11", "restart address", col_addr, 50);
        step(0, '0, 1, 60, 0, 1, 1, "R11");
        check("R11", "start beats stop", col_valid, 1);
        idle(8, "R11");

        // R12: mode write mid-burst
        step(0, '0, 1, 8, 0, 0, 1, "R12");
        mode(12'h011, "R12");
        idle(7, "R12");
        check("R12", "burst kept length 8", col_valid, 0);
        step(0, '0, 1, 8, 0, 0, 1, "R12"); idle(2, "R12");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit mw = ($urandom % 40) == 0;
            logic [11:0] op;
            int bl;
            if (($urandom % 4) == 0) op = 12'($urandom);
            else begin
                case ($urandom % 5)
                    0: bl = 0; 1: bl = 1; 2: bl = 2; 3: bl = 3; default: bl = 7;
                endcase
                op = {2'b00, 1'($urandom), 2'b00, 3'(1 + $urandom % 3),
                      1'(($urandom % 8) == 0 ? 1 : (bl != 7 ? $urandom : 0)), 3'(bl)};
            end
            tg = (c_il != 0) ? "R4" : ((len_mask(c_len) == PAGE - 1) ? "R5" : "R3");
            step(mw, op, ($urandom % 7) == 0, int'($urandom % PAGE), 1'($urandom),
                 ($urandom % 25) == 0, ($urandom % 10) != 0, tg);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule